// File: doc/BRIEF.md
# Q15 Fractional Multiply-Accumulate Unit

This block carries out fractional multiply-accumulate operations on a pair of 32-bit accumulator registers, HI and LO. Each operation takes one signed 16-bit halfword of a 64-bit first operand, chosen by a 2-bit lane number, and multiplies it by the signed low halfword of a 64-bit second operand. The product is doubled so that two Q15 fractions give a Q31 fraction. The one case that cannot be represented, minus one times minus one, is pinned to the largest positive Q31 value.

The operation is given as a 32-bit instruction word, and a small decoder inside the block finds the lane and the accumulation mode in it. In plain mode the product is added to the 64-bit value formed by HI above LO, and carries run into HI. In saturating mode only LO is updated, with its result clamped to the signed 32-bit range, and bit 0 of HI collects every clamp as a sticky overflow flag. A load port writes both registers directly, so that a test can start from any accumulator state.

Top module: `q15mac_top`

## Requirements
- R1: A synchronous active-high reset sets acc_hi and acc_lo to zero at the clock edge where rst is high.
- R2: An instruction word is accepted only when insn_valid is high, bits 31:26 are 011100, bits 5:0 are 010010, bits 15:11 are zero, and bits 10:8 are 100 (plain mode) or 000 (saturating mode). Any other word leaves HI and LO unchanged. Bits 25:16 do not matter.
- R3: Bits 7:6 of the word give the lane L. The multiplicand is src_a[16L+15:16L] and the multiplier is src_b[15:0], both signed. Their product is doubled to give a signed 32-bit value.
- R4: When both halfwords are 0x8000, the doubled product is replaced by 0x7FFFFFFF. In saturating mode this case also sets HI bit 0.
- R5: In plain mode, {HI,LO} becomes {HI,LO} plus the product sign-extended to 64 bits, modulo 2^64. A carry or borrow out of LO changes HI.
- R6: In saturating mode, LO becomes the sign-extended old LO plus the product, clamped to the range 0x80000000..0x7FFFFFFF.
- R7: In saturating mode, HI bit 0 is ORed with the product clamp flag and with the LO clamp flag, so this mode never clears it. HI bits 31:1 do not change. A later plain operation that causes no carry into HI leaves the flag set.
- R8: When ld_en is high, acc_hi and acc_lo take ld_hi and ld_lo at the next edge, even if an operation is accepted in the same cycle.
- R9: Each accepted word performs exactly one operation, and its result appears at the clock edge that samples it. When there is no load and no accepted word, HI and LO hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word strobe |
| insn_word | input | 32 | Instruction word carrying the mode and lane |
| src_a | input | 64 | First operand, four signed halfword lanes |
| src_b | input | 64 | Second operand; only bits 15:0 are used |
| ld_en | input | 1 | Direct load of the accumulator |
| ld_hi | input | 32 | Load value for HI |
| ld_lo | input | 32 | Load value for LO |
| acc_hi | output | 32 | HI accumulator |
| acc_lo | output | 32 | LO accumulator |

## Verification
On every cycle the assertions check four things: reset clearing, the load taking priority, the accumulator holding when nothing is accepted, and, in saturating mode, HI bits 31:1 staying unchanged while bit 0 is only ever set (including its setting by the minus-one-squared product). The arithmetic can only be shown by the bench's scenarios, which compare against a behavioural model on every clock. Those scenarios cover lane selection, carries from LO into HI, positive and negative clamping of LO, the flag surviving a later plain operation, and the rejection of near-miss instruction words.

// File: rtl/q15mac_pkg.sv
package q15mac_pkg;

    localparam int unsigned INSN_W  = 32;
    localparam int unsigned ACC_W   = 32;
    localparam int unsigned HALF_W  = 16;
    localparam int unsigned N_LANES = 4;
    localparam int unsigned LANE_SW = $clog2(N_LANES);
    localparam int unsigned OPND_W  = HALF_W * N_LANES;

    // instruction field positions
    localparam int unsigned MAJ_LSB  = 26;
    localparam int unsigned ZERO_LSB = 11;
    localparam int unsigned SUB_LSB  = 8;
    localparam int unsigned LANE_LSB = 6;

    localparam logic [5:0] MAJ_CODE  = 6'b011100;
    localparam logic [5:0] FUNC_CODE = 6'b010010;
    localparam logic [2:0] SUB_PLAIN = 3'b100;
    localparam logic [2:0] SUB_SAT   = 3'b000;

    typedef enum logic {
        ACC_PLAIN = 1'b0,
        ACC_SAT   = 1'b1
    } acc_mode_e;

    typedef struct packed {
        logic               fire;
        acc_mode_e          mode;
        logic [LANE_SW-1:0] lane;
    } mac_op_t;

    typedef struct packed {
        logic [ACC_W-1:0] hi;
        logic [ACC_W-1:0] lo;
    } acc_pair_t;

    typedef struct packed {
        logic [ACC_W-1:0] value;
        logic             clamped;
    } q31_prod_t;

    // most positive and most negative signed value of a given width
    function automatic logic [ACC_W:0] wide_max();
        logic [ACC_W:0] r;
        r = '0;
        r[ACC_W-2:0] = '1;
        r[ACC_W-1]   = 1'b0;
        return r;
    endfunction

    function automatic logic [ACC_W:0] wide_min();
        logic [ACC_W:0] r;
        r = '1;
        r[ACC_W-2:0] = '0;
        return r;
    endfunction

endpackage

// File: rtl/q15mac_decode.sv
module q15mac_decode
    import q15mac_pkg::*;
(
    input  logic              valid,
    input  logic [INSN_W-1:0] word,
    output mac_op_t           op
);
    logic [5:0]         major;
    logic [5:0]         func;
    logic [4:0]         zeros;
    logic [2:0]         sub;
    logic               shape_ok;
    logic               is_plain;
    logic               is_sat;

    always_comb begin
        major    = word[MAJ_LSB +: 6];
        func     = word[5:0];
        zeros    = word[ZERO_LSB +: 5];
        sub      = word[SUB_LSB +: 3];
        shape_ok = (major == MAJ_CODE) && (func == FUNC_CODE) && (zeros == 5'd0);
        is_plain = shape_ok && (sub == SUB_PLAIN);
        is_sat   = shape_ok && (sub == SUB_SAT);
        op.fire  = valid && (is_plain || is_sat);
        op.mode  = is_sat ? ACC_SAT : ACC_PLAIN;
        op.lane  = word[LANE_LSB +: LANE_SW];
    end
endmodule

// File: rtl/q15mac_mul.sv
module q15mac_mul
    import q15mac_pkg::*;
#(
    parameter int unsigned LANE_W = HALF_W,
    parameter int unsigned LANES  = N_LANES,
    localparam int unsigned SEL_W = $clog2(LANES),
    localparam int unsigned PROD_W = 2 * LANE_W
)(
    input  logic [LANE_W*LANES-1:0] src_a,
    input  logic [LANE_W-1:0]       mul_b,
    input  logic [SEL_W-1:0]        lane,
    output logic [PROD_W-1:0]       q_value,
    output logic                    q_clamped
);
    logic signed [LANE_W-1:0] lane_v [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_v[g] = src_a[g*LANE_W +: LANE_W];
    end

    logic signed [LANE_W-1:0] sel_a;
    logic signed [LANE_W-1:0] sel_b;
    logic signed [PROD_W-1:0] raw;
    logic        [PROD_W-1:0] dbl;
    logic        [LANE_W-1:0] neg_one;
    logic        [PROD_W-1:0] pos_max;

    always_comb begin
        neg_one           = '0;
        neg_one[LANE_W-1] = 1'b1;
        pos_max           = '1;
        pos_max[PROD_W-1] = 1'b0;
        sel_a     = lane_v[lane];
        sel_b     = mul_b;
        raw       = PROD_W'(sel_a) * PROD_W'(sel_b);
        dbl       = {raw[PROD_W-2:0], 1'b0};
        q_clamped = (sel_a == neg_one) && (sel_b == neg_one);
        q_value   = q_clamped ? pos_max : dbl;
    end
endmodule

// File: rtl/q15mac_acc.sv
module q15mac_acc
    import q15mac_pkg::*;
(
    input  acc_mode_e  mode,
    input  acc_pair_t  cur,
    input  q31_prod_t  prod,
    output acc_pair_t  nxt
);
    logic [2*ACC_W-1:0] full_sum;
    logic [ACC_W:0]     wide;
    logic [ACC_W:0]     lim_hi;
    logic [ACC_W:0]     lim_lo;
    logic               over_pos;
    logic               over_neg;
    logic [ACC_W-1:0]   sat_lo;
    logic               flag;

    always_comb begin
        lim_hi   = wide_max();
        lim_lo   = wide_min();
        full_sum = {cur.hi, cur.lo}
                 + {{ACC_W{prod.value[ACC_W-1]}}, prod.value};
        wide     = {cur.lo[ACC_W-1], cur.lo} + {prod.value[ACC_W-1], prod.value};
        over_pos = $signed(wide) > $signed(lim_hi);
        over_neg = $signed(wide) < $signed(lim_lo);
        if (over_pos)      sat_lo = lim_hi[ACC_W-1:0];
        else if (over_neg) sat_lo = lim_lo[ACC_W-1:0];
        else               sat_lo = wide[ACC_W-1:0];
        flag = prod.clamped || over_pos || over_neg;

        if (mode == ACC_SAT) begin
            nxt.lo = sat_lo;
            nxt.hi = {cur.hi[ACC_W-1:1], cur.hi[0] | flag};
        end else begin
            nxt.hi = full_sum[2*ACC_W-1:ACC_W];
            nxt.lo = full_sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/q15mac_top.sv
module q15mac_top
    import q15mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn_word,
    input  logic [OPND_W-1:0] src_a,
    input  logic [OPND_W-1:0] src_b,
    input  logic              ld_en,
    input  logic [ACC_W-1:0]  ld_hi,
    input  logic [ACC_W-1:0]  ld_lo,
    output logic [ACC_W-1:0]  acc_hi,
    output logic [ACC_W-1:0]  acc_lo
);
    mac_op_t   dec_op;
    q31_prod_t prod;
    acc_pair_t acc_q;
    acc_pair_t acc_nxt;

    logic op_fire;
    logic op_sat;
    logic prod_clamp;

    q15mac_decode i_dec (
        .valid (insn_valid),
        .word  (insn_word),
        .op    (dec_op)
    );

    q15mac_mul #(
        .LANE_W (HALF_W),
        .LANES  (N_LANES)
    ) i_mul (
        .src_a     (src_a),
        .mul_b     (src_b[HALF_W-1:0]),
        .lane      (dec_op.lane),
        .q_value   (prod.value),
        .q_clamped (prod.clamped)
    );

    q15mac_acc i_acc (
        .mode (dec_op.mode),
        .cur  (acc_q),
        .prod (prod),
        .nxt  (acc_nxt)
    );

    always_comb begin
        op_fire    = dec_op.fire;
        op_sat     = (dec_op.mode == ACC_SAT);
        prod_clamp = prod.clamped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (ld_en) begin
            acc_q.hi <= ld_hi;
            acc_q.lo <= ld_lo;
        end else if (op_fire) begin
            acc_q <= acc_nxt;
        end
    end

    assign acc_hi = acc_q.hi;
    assign acc_lo = acc_q.lo;
endmodule

// File: rtl/q15mac_checker.sv
module q15mac_checker (
    input logic        clk,
    input logic        rst,
    input logic        op_fire,
    input logic        op_sat,
    input logic        prod_clamp,
    input logic        ld_en,
    input logic [31:0] ld_hi,
    input logic [31:0] ld_lo,
    input logic [31:0] acc_hi,
    input logic [31:0] acc_lo
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc_hi == 32'd0) && (acc_lo == 32'd0));

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (acc_hi == $past(ld_hi)) && (acc_lo == $past(ld_lo)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !op_fire) |=> ($stable(acc_hi) && $stable(acc_lo)));

    assert_sat_upper_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (op_fire && op_sat && !ld_en) |=> (acc_hi[31:1] == $past(acc_hi[31:1])));

    assert_sticky_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (op_fire && op_sat && !ld_en && acc_hi[0]) |=> acc_hi[0]);

    assert_clamp_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (op_fire && op_sat && !ld_en && prod_clamp) |=> acc_hi[0]);
endmodule

bind q15mac_top q15mac_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .op_fire    (op_fire),
    .op_sat     (op_sat),
    .prod_clamp (prod_clamp),
    .ld_en      (ld_en),
    .ld_hi      (ld_hi),
    .ld_lo      (ld_lo),
    .acc_hi     (acc_hi),
    .acc_lo     (acc_lo)
);

// File: tb/test_q15mac_top.sv
module test_q15mac_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = 32'd0;
    logic [63:0] src_a = 64'd0;
    logic [63:0] src_b = 64'd0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_hi = 32'd0;
    logic [31:0] ld_lo = 32'd0;
    logic [31:0] acc_hi;
    logic [31:0] acc_lo;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    logic [31:0] m_hi = 32'd0;
    logic [31:0] m_lo = 32'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    q15mac_top i_q15mac_top (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
        .src_a(src_a), .src_b(src_b), .ld_en(ld_en), .ld_hi(ld_hi),
        .ld_lo(ld_lo), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    function automatic logic [31:0] mk_word(bit sat, logic [1:0] lane);
        return {6'b011100, 5'd7, 5'd9, 5'd0, (sat ? 3'b000 : 3'b100), lane, 6'b010010};
    endfunction

    // behavioural reference for one clock edge
    task automatic model_edge();
        logic signed [15:0] ah;
        logic signed [15:0] bh;
        longint p;
        longint s;
        logic [63:0] u;
        bit accept;
        bit sat;
        bit flg;
        int ln;
        accept = insn_valid && insn_word[31:26] == 6'b011100 && insn_word[5:0] == 6'b010010
              && insn_word[15:11] == 5'd0
              && (insn_word[10:8] == 3'b100 || insn_word[10:8] == 3'b000);
        sat = (insn_word[10:8] == 3'b000);
        ln  = int'(insn_word[7:6]);
        if (rst) begin
            m_hi = 0; m_lo = 0;
        end else if (ld_en) begin
            m_hi = ld_hi; m_lo = ld_lo;
        end else if (accept) begin
            ah = src_a[ln*16 +: 16];
            bh = src_b[15:0];
            p = longint'(ah) * longint'(bh) * 2;
            flg = 0;
            if (p > 64'sd2147483647) begin p = 64'sd2147483647; flg = 1; end
            if (!sat) begin
                u = {m_hi, m_lo} + 64'(p);
                m_hi = u[63:32]; m_lo = u[31:0];
            end else begin
                s = longint'($signed(m_lo)) + p;
                if (s > 64'sd2147483647) begin s = 64'sd2147483647; flg = 1; end
                if (s < -64'sd2147483648) begin s = -64'sd2147483648; flg = 1; end
                m_lo = 32'(s);
                m_hi[0] = m_hi[0] | flg;
            end
        end
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: model follows the edge, outputs compared mid-low phase
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(cur_req, "acc_hi", acc_hi, m_hi);
        check(cur_req, "acc_lo", acc_lo, m_lo);
    endtask

    task automatic idle();
        insn_valid = 0; ld_en = 0;
    endtask

    task automatic do_op(bit sat, logic [1:0] lane, logic [63:0] a, logic [63:0] b);
        insn_valid = 1; insn_word = mk_word(sat, lane); src_a = a; src_b = b; ld_en = 0;
        tick();
        idle();
    endtask

    task automatic do_load(logic [31:0] h, logic [31:0] l);
        ld_en = 1; ld_hi = h; ld_lo = l; insn_valid = 0;
        tick();
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        cur_req = "R1";
        m_hi = 32'hDEAD_BEEF; m_lo = 32'hDEAD_BEEF;
        rst = 1;
        tick();
        check("R1", "reset hi zero", acc_hi, 32'd0);
        check("R1", "reset lo zero", acc_lo, 32'd0);
        rst = 0;

        // R3: each lane selected, plain mode
        cur_req = "R3";
        for (int ln = 0; ln < 4; ln++) begin
            do_load(32'd0, 32'd0);
            do_op(0, 2'(ln), 64'h4000_2000_1000_0800, 64'h0000_0000_0000_0003);
        end
        do_op(0, 2'd2, 64'h0000_FFFF_0000_0000, 64'h0000_0000_0000_0005);

        // R4: -1 * -1 in plain then saturating
        cur_req = "R4";
        do_load(32'd0, 32'd0);
        do_op(0, 2'd1, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_8000);
        check("R4", "plain clamp lo", acc_lo, 32'h7FFF_FFFF);
        do_load(32'd0, 32'd0);
        do_op(1, 2'd3, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_8000);
        check("R4", "sat clamp sets flag", acc_hi, 32'h0000_0001);

        // R5: carry out of LO into HI, and borrow
        cur_req = "R5";
        do_load(32'h0000_0010, 32'hFFFF_FFF0);
        do_op(0, 2'd0, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0001);
        check("R5", "carry into hi", acc_hi, 32'h0000_0011);
        do_load(32'h0000_0010, 32'h0000_0000);
        do_op(0, 2'd0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001);
        check("R5", "borrow from hi", acc_hi, 32'h0000_000F);

        // R6: positive and negative saturation of LO
        cur_req = "R6";
        do_load(32'hA5A5_A5A4, 32'h7FFF_0000);
        do_op(1, 2'd0, 64'h0000_0000_0000_7FFF, 64'h0000_0000_0000_7FFF);
        check("R6", "pos sat lo", acc_lo, 32'h7FFF_FFFF);
        check("R7", "pos sat hi", acc_hi, 32'hA5A5_A5A5);
        do_load(32'h0000_0000, 32'h8000_0100);
        do_op(1, 2'd2, 64'h0000_8000_0000_0000, 64'h0000_0000_0000_7FFF);
        check("R6", "neg sat lo", acc_lo, 32'h8000_0000);
        do_load(32'h0000_0000, 32'h0000_1000);
        do_op(1, 2'd1, 64'h0000_0000_0100_0000, 64'h0000_0000_0000_FFFF);
        check("R6", "no sat lo", acc_lo, 32'h0000_0E00);
        check("R7", "no sat flag clear", acc_hi, 32'h0000_0000);

        // R7: flag survives further sat ops and a plain op without carry
        cur_req = "R7";
        do_load(32'h0000_0000, 32'h7FFF_FFF0);
        do_op(1, 2'd0, 64'h0000_0000_0000_4000, 64'h0000_0000_0000_4000);
        do_op(1, 2'd0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001);
        check("R7", "flag kept by sat", acc_hi[0], 1'b1);
        do_op(0, 2'd0, 64'h0000_0000_0000_F000, 64'h0000_0000_0000_0001);
        check("R7", "flag kept by plain", acc_hi[0], 1'b1);

        // R2: near-miss words ignored
        cur_req = "R2";
        do_load(32'h1234_5678, 32'h0000_0100);
        src_a = 64'h0000_0000_0000_4000; src_b = 64'h0000_0000_0000_4000;
        insn_valid = 1;
        insn_word = mk_word(0, 2'd0) | 32'h0000_0800;    tick();
        insn_word = mk_word(0, 2'd0) ^ 32'h0000_0200;    tick();
        insn_word = mk_word(1, 2'd0) ^ 32'h0400_0000;    tick();
        insn_word = mk_word(1, 2'd0) ^ 32'h0000_0001;    tick();
        insn_valid = 0; insn_word = mk_word(0, 2'd0);    tick();
        check("R2", "ignored hi", acc_hi, 32'h1234_5678);
        check("R2", "ignored lo", acc_lo, 32'h0000_0100);

        // R8: load beats a same-cycle op
        cur_req = "R8";
        insn_valid = 1; insn_word = mk_word(0, 2'd0); ld_en = 1;
        ld_hi = 32'hCAFE_0001; ld_lo = 32'h0BAD_F00D;
        tick();
        idle();
        check("R8", "load hi", acc_hi, 32'hCAFE_0001);
        check("R8", "load lo", acc_lo, 32'h0BAD_F00D);

        // R9: idle cycles hold, then random mix against the model
        cur_req = "R9";
        for (int i = 0; i < 3; i++) tick();
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            src_a = {$urandom, $urandom};
            src_b = {$urandom, $urandom};
            if (r[3:0] == 4'd0) src_a[15:0] = 16'h8000;
            if (r[5:4] == 2'd0) src_b[15:0] = 16'h8000;
            insn_word = mk_word(r[6], r[8:7]);
            if (r[11:9] == 3'd0) insn_word[10:8] = 3'(r[14:12]);
            if (r[16:15] == 2'd0) insn_word[25:16] = 10'(r[26:17]);
            insn_valid = (r[19:17] != 3'd0);
            ld_en = (r[23:20] == 4'd0);
            ld_hi = $urandom; ld_lo = $urandom;
            tick();
        end
        idle();
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule